// File: doc/BRIEF.md
# Memory Address Decoder with Boot-ROM Overlay

This block sits between an 8-bit processor's 16-bit address bus and the memories around it. On every cycle with a read or write strobe it picks exactly one target region and raises that region's select line. It also gives the address relative to the start of that region, and it flags whether the write may change anything. The decode is combinational, so a memory can use the select and offset in the same cycle as the strobe.

A one-bit overlay register decides who answers low addresses. After reset, reads from the first 256 bytes are served by a small start-up ROM instead of the cartridge. The first read of address 0x0100 turns the overlay off for good, and only a reset brings it back.

The region at 0xE000–0xFDFF is a mirror of working RAM. Writes to cartridge ROM are dropped. The hole at 0xFEA0–0xFEFF has its own select, and the data path answers reads there with the constant 0xFF.

Top module: `addr_route`

## Requirements
- R1: With neither `rd_en` nor `wr_en` high, every bit of `sel` is 0 and `wr_ok` is 0.
- R2: With `rd_en` or `wr_en` high, exactly one bit of `sel` is 1.
- R3: The `sel` bit indices follow the address map below. Each row is one region.

  | Bit | Region | Address range |
  |---|---|---|
  | 1 | cartridge ROM | 0x0000–0x7FFF |
  | 2 | video RAM | 0x8000–0x9FFF |
  | 3 | cartridge RAM | 0xA000–0xBFFF |
  | 4 | working RAM | 0xC000–0xDFFF |
  | 5 | object attribute memory | 0xFE00–0xFE9F |
  | 6 | unused region | 0xFEA0–0xFEFF |
  | 7 | I/O registers | 0xFF00–0xFF7F |
  | 8 | zero-page RAM | 0xFF80–0xFFFE |
  | 9 | interrupt-enable register | 0xFFFF |

  Bit 6 marks a read whose data is the constant 0xFF.
- R4: `offset` equals the address minus the start address of the selected region, truncated to `OFS_W` bits. The start address of the boot ROM region is 0x0000.
- R5: Addresses 0xE000–0xFDFF select working RAM (bit 4), with `offset` equal to the address minus 0xE000.
- R6: After reset the overlay is active. While it is active, a read of 0x0000–0x00FF selects the boot ROM (bit 0) with `offset` equal to the address.
- R7: The overlay turns off at the rising clock edge that samples `rd_en` high with address 0x0100. That read itself selects cartridge ROM. Writes to 0x0100 and reads of any other address leave the overlay unchanged.
- R8: Once the overlay is off it stays off until reset. Reads of 0x0000–0x00FF then select cartridge ROM.
- R9: Writes below 0x0100 select cartridge ROM even while the overlay is active.
- R10: `wr_ok` is 1 only when `wr_en` is high and the selected region is one of the following: video RAM, cartridge RAM, working RAM (including its mirror), object attribute memory, I/O, zero-page RAM or interrupt-enable. Writes to cartridge ROM or to the unused region give `wr_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; sets the overlay active |
| addr | input | 16 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| sel | output | 10 | One-hot region select, bit indices as in R3 and R6 |
| offset | output | OFS_W (15) | Address relative to the start of the selected region |
| wr_ok | output | 1 | Write will take effect |

## Verification
The bench builds the block with its defaults: `OFS_W` = 15, which is enough for the 32 KiB cartridge ROM offset, and the overlay end at 0x0100. With those values the full 16-bit address space is small enough to sweep every address, once as a read and once as a write. Every region boundary, the mirror edges and the single-address interrupt-enable region are therefore all covered. The overlay is exercised before and after the clearing read, against writes to 0x0100 that must not clear it, and across a second reset that must restore it.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

    localparam int ADDR_W = 16;
    localparam int NREG   = 10;

    typedef enum logic [3:0] {
        RG_BOOT  = 4'd0,
        RG_CROM  = 4'd1,
        RG_VRAM  = 4'd2,
        RG_CRAM  = 4'd3,
        RG_WRAM  = 4'd4,
        RG_OAM   = 4'd5,
        RG_VOID  = 4'd6,
        RG_IOREG = 4'd7,
        RG_ZPAGE = 4'd8,
        RG_IEREG = 4'd9
    } region_e;

    // upper bounds (exclusive) of each window
    localparam logic [ADDR_W-1:0] END_CROM  = 16'h8000;
    localparam logic [ADDR_W-1:0] END_VRAM  = 16'hA000;
    localparam logic [ADDR_W-1:0] END_CRAM  = 16'hC000;
    localparam logic [ADDR_W-1:0] END_WRAM  = 16'hE000;
    localparam logic [ADDR_W-1:0] END_ECHO  = 16'hFE00;
    localparam logic [ADDR_W-1:0] END_OAM   = 16'hFEA0;
    localparam logic [ADDR_W-1:0] END_VOID  = 16'hFF00;
    localparam logic [ADDR_W-1:0] END_IOREG = 16'hFF80;
    localparam logic [ADDR_W-1:0] ADR_IEREG = 16'hFFFF;

    // regions that accept writes
    localparam logic [NREG-1:0] WR_MASK = 10'b11_1011_1100;

    typedef struct packed {
        logic active;
    } boot_st_t;

    function automatic logic [ADDR_W-1:0] region_base(input region_e r, input logic echo);
        case (r)
            RG_VRAM:  region_base = END_CROM;
            RG_CRAM:  region_base = END_VRAM;
            RG_WRAM:  region_base = echo ? END_WRAM : END_CRAM;
            RG_OAM:   region_base = END_ECHO;
            RG_VOID:  region_base = END_OAM;
            RG_IOREG: region_base = END_VOID;
            RG_ZPAGE: region_base = END_IOREG;
            RG_IEREG: region_base = ADR_IEREG;
            default:  region_base = '0;
        endcase
    endfunction

endpackage

// File: rtl/addr_boot_latch.sv
module addr_boot_latch
    import addr_route_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOOT_END = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    output logic              active
);

    boot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en && (addr == BOOT_END)) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

endmodule

// File: rtl/addr_region_dec.sv
module addr_region_dec
    import addr_route_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOOT_END = 16'h0100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              boot_active,
    output region_e           region,
    output logic              echo
);

    always_comb begin
        echo = 1'b0;
        if (boot_active && rd_en && (addr < BOOT_END)) begin
            region = RG_BOOT;
        end else if (addr < END_CROM) begin
            region = RG_CROM;
        end else if (addr < END_VRAM) begin
            region = RG_VRAM;
        end else if (addr < END_CRAM) begin
            region = RG_CRAM;
        end else if (addr < END_WRAM) begin
            region = RG_WRAM;
        end else if (addr < END_ECHO) begin
            region = RG_WRAM;
            echo   = 1'b1;
        end else if (addr < END_OAM) begin
            region = RG_OAM;
        end else if (addr < END_VOID) begin
            region = RG_VOID;
        end else if (addr < END_IOREG) begin
            region = RG_IOREG;
        end else if (addr != ADR_IEREG) begin
            region = RG_ZPAGE;
        end else begin
            region = RG_IEREG;
        end
    end

endmodule

// File: rtl/addr_offset_gen.sv
module addr_offset_gen
    import addr_route_pkg::*;
#(
    parameter int OFS_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  region_e           region,
    input  logic              echo,
    output logic [OFS_W-1:0]  offset
);

    always_comb begin
        offset = OFS_W'(addr - region_base(region, echo));
    end

endmodule

// File: rtl/addr_route.sv
module addr_route
    import addr_route_pkg::*;
#(
    parameter int                OFS_W    = 15,
    parameter logic [ADDR_W-1:0] BOOT_END = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [NREG-1:0]   sel,
    output logic [OFS_W-1:0]  offset,
    output logic              wr_ok
);

    logic    boot_active;
    logic    access;
    logic    echo;
    region_e region;

    assign access = rd_en | wr_en;

    addr_boot_latch #(.BOOT_END(BOOT_END)) u_boot (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .rd_en  (rd_en),
        .active (boot_active)
    );

    addr_region_dec #(.BOOT_END(BOOT_END)) u_dec (
        .addr        (addr),
        .rd_en       (rd_en),
        .boot_active (boot_active),
        .region      (region),
        .echo        (echo)
    );

    addr_offset_gen #(.OFS_W(OFS_W)) u_ofs (
        .addr   (addr),
        .region (region),
        .echo   (echo),
        .offset (offset)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = access && (region == region_e'(i));
    end

    assign wr_ok = wr_en && |(sel & WR_MASK);

endmodule

// File: rtl/addr_route_chk.sv
module addr_route_chk
    import addr_route_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [NREG-1:0]   sel,
    input logic              wr_ok,
    input logic              boot_q
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> (sel == '0) && !wr_ok); // R1

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> ($countones(sel) == 1)); // R2

    AST_ECHO_WRAM: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr >= 16'hE000 && addr < 16'hFE00) |-> sel[4]); // R5

    AST_BOOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 16'h0100) |=> !boot_q); // R7

    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_q |=> !boot_q); // R8

    AST_BOOT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr < 16'h0100) |-> (sel[1] && !sel[0])); // R9

    AST_ROM_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < 16'h8000) |-> !wr_ok); // R10

endmodule

bind addr_route addr_route_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .sel    (sel),
    .wr_ok  (wr_ok),
    .boot_q (boot_active)
);

// File: tb/sim_addr_route.sv
`timescale 1ns/1ps
module sim_addr_route;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  sel;
    logic [14:0] offset;
    logic        wr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_boot = 1'b1;

    always #10 clk = ~clk;

    addr_route u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .sel(sel), .offset(offset), .wr_ok(wr_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%0h expected=%0h",
                     req, addr, rd_en, wr_en, act, exp);
        end
    endtask

    function automatic int exp_idx(input int a, input bit boot, input bit rd);
        if (boot && rd && a < 'h100) return 0;
        if (a < 'h8000) return 1;
        if (a < 'hA000) return 2;
        if (a < 'hC000) return 3;
        if (a < 'hFE00) return 4;
        if (a < 'hFEA0) return 5;
        if (a < 'hFF00) return 6;
        if (a < 'hFF80) return 7;
        if (a < 'hFFFF) return 8;
        return 9;
    endfunction

    function automatic int exp_base(input int a, input int idx);
        case (idx)
            2: return 'h8000;
            3: return 'hA000;
            4: return (a >= 'hE000) ? 'hE000 : 'hC000;
            5: return 'hFE00;
            6: return 'hFEA0;
            7: return 'hFF00;
            8: return 'hFF80;
            9: return 'hFFFF;
            default: return 0;
        endcase
    endfunction

    // one access cycle: drive at negedge, check, then let the edge happen
    task automatic acc(input int a, input bit r, input bit w);
        int idx;
        string rq;
        @(negedge clk);
        addr = 16'(a); rd_en = r; wr_en = w;
        #2;
        if (!r && !w) begin
            check("R1 sel idle", int'(sel), 0);
            check("R1 wr_ok idle", int'(wr_ok), 0);
        end else begin
            idx = exp_idx(a, model_boot, r);
            if (idx == 0) rq = "R6 sel";
            else if (a < 'h100 && w && model_boot) rq = "R9 sel";
            else if (a < 'h100 && !model_boot) rq = "R8 sel";
            else if (a >= 'hE000 && a < 'hFE00) rq = "R5 sel";
            else rq = "R3 sel";
            check(rq, int'(sel), 1 << idx);
            check("R2 onehot", $countones(sel), 1);
            check((a >= 'hE000 && a < 'hFE00) ? "R5 offset" : "R4 offset",
                  int'(offset), (a - exp_base(a, idx)) & 'h7FFF);
            check("R10 wr_ok", int'(wr_ok),
                  int'(w && idx != 0 && idx != 1 && idx != 6));
        end
        @(posedge clk);
        if (r && a == 'h100) model_boot = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_boot = 1'b1;
    endtask

    initial begin
        do_reset();
        acc('h0000, 0, 0);                       // R1 reset/idle
        for (int a = 0; a < 'h100; a++) acc(a, 1, 0);   // R6
        acc('h0100, 0, 1);                       // R7 write must not clear
        acc('h0042, 1, 0);                       // R7 still boot
        acc('h0050, 0, 1);                       // R9
        acc('h00FF, 0, 1);                       // R9
        acc('h0200, 1, 0);                       // R7 other read
        acc('h0000, 1, 0);                       // R7 still boot
        acc('h0100, 1, 0);                       // R7 clearing read -> ROM
        acc('h0000, 1, 0);                       // R8 now ROM
        acc('h00FF, 1, 0);                       // R8
        for (int a = 0; a < 'h10000; a++) acc(a, 1, 0); // R3 R4 R5 R8
        for (int a = 0; a < 'h10000; a++) acc(a, 0, 1); // R3 R10
        acc('h1234, 0, 0);                       // R1
        acc('h0080, 1, 0);                       // R8 stays off
        do_reset();
        acc('h0080, 1, 0);                       // R6 overlay restored
        acc('hFFFF, 1, 1);                       // R10 read+write to IE
        acc('hFEA0, 1, 1);                       // R10 unused
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule